// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

A memory-mapped serial master that sits on a simple 32-bit register bus with single-cycle write and read strobes. Software queues 8-bit frames by writing a transmit data port; a shift engine sends each frame on a serial clock and data-out line while it captures the data-in line into a receive queue that software drains through a receive data port. Both queues hold 16 frames. Clock polarity, clock phase, bit order and an internal loopback path are selected in the control register, and a hold bit lets software fill the transmit queue before any frame moves.

Chip selects are active low and come from a one-hot select register. In manual mode they follow that register at all times, so one device stays selected across many frames. In automatic mode the selected line drops only while a frame is in flight. Interrupt enable and status registers are plain read/write storage. A keyed write to the reset register returns every register and both queues to their reset state.

The shift engine is a five-state machine. IDLE waits for a queued frame while the engine is allowed to run and pops it (IDLE to SETUP). SETUP holds the select for half a serial clock period with the clock at its idle level (SETUP to LEAD). LEAD is the first half of a bit and ends on the sampling edge (LEAD to TRAIL). TRAIL is the second half of a bit. It returns to LEAD for the next bit (TRAIL to LEAD) or, after the eighth bit, moves on (TRAIL to HOLD). HOLD keeps the select for half a period and then writes the captured frame into the receive queue (HOLD to IDLE).

Top module: `spi_regbus_master`

## Requirements
- R1: After reset the control register reads 0x180 (hold and manual select set), the status register reads 0x05, the select register reads all ones, and the serial clock is low.
- R2: Byte offsets: 0x1C interrupt global enable (bit 31 stored), 0x20 interrupt status and 0x28 interrupt enable (low 9 bits stored, read back as written, no interrupt output), 0x40 reset key, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data, 0x70 select, 0x74 transmit occupancy, 0x78 receive occupancy.
- R3: Writing 0x0000000A to offset 0x40 returns all registers and both queues to their reset state on the next cycle; any other value written there changes nothing.
- R4: Control bit 1 is enable, bit 2 is master, bit 8 is hold. A frame starts only when enable and master are 1 and hold is 0; otherwise queued frames stay queued and the serial clock does not toggle.
- R5: The serial clock runs at the system clock divided by DIV (default 4, one period 40 ns at 100 MHz). Control bit 3 (CPOL) sets the idle level. Control bit 4 (CPHA) = 0 samples data-in on the first clock edge of each bit, CPHA = 1 on the second edge.
- R6: Control bit 9 = 0 sends and receives the most significant bit first; = 1 sends and receives the least significant bit first.
- R7: With control bit 0 set, data-out is routed internally to the receive shifter, so each received frame equals the frame sent and the data-in pin is ignored.
- R8: Select lines are active low and one-hot; clearing bit n of the select register selects device n. With control bit 7 (manual) set, the select outputs always equal the register. With it clear they are all ones while the engine is in IDLE and equal the register during a frame.
- R9: Each queue holds 16 frames; only bits 7:0 of a transmit write are used. A write to a full transmit queue is dropped. Each occupancy register reads the frame count minus one in bits 3:0.
- R10: A read of the receive port while the receive queue is empty returns 0 and leaves the queue unchanged.
- R11: Writing 1 to control bit 5 empties the transmit queue and writing 1 to bit 6 empties the receive queue in the cycle of the write; both bits read back as 0.
- R12: Status bit 0 is receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full; bits 4 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; pops the receive queue at offset 0x6C |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low device selects |

## Verification
A wrong engine state shows at the pins within half a serial clock period: a select that stays low in automatic mode while idle, a clock that leaves its idle level while held, or a frame with one bit too many or too few, which corrupts the byte the external device model captures and the byte read back through the receive port. Queue pointer faults show one frame later, as a received byte that does not match the scoreboard or an occupancy value that is off by one. A faulty reset key decode shows on the next control register read.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int CTRL_W = 10;

    localparam logic [ADDR_W-1:0] OFS_GIE   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ISR   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IER   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_SRST  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_SEL   = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_TXOCC = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_RXOCC = 8'h78;

    localparam int CB_LOOP   = 0;
    localparam int CB_ENABLE = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXCLR  = 5;
    localparam int CB_RXCLR  = 6;
    localparam int CB_MANSEL = 7;
    localparam int CB_HOLD   = 8;
    localparam int CB_LSBF   = 9;

    localparam logic [CTRL_W-1:0] CTRL_RESET    = 10'h180;
    localparam logic [CTRL_W-1:0] CTRL_PULSE_MK = 10'h060;
    localparam logic [BUS_W-1:0]  SRST_KEY      = 32'h0000_000A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL,
        ST_HOLD
    } eng_state_t;

endpackage

// File: rtl/spi_rb_fifo.sv
module spi_rb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
    import spi_rb_pkg::*;
#(
    parameter int DIV  = 4,
    parameter int FW   = 8,
    localparam int HALF = DIV / 2,
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BCW  = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run_ok,
    input  logic          tx_avail,
    input  logic [FW-1:0] tx_byte,
    output logic          tx_take,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          loop_en,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          rx_put,
    output logic [FW-1:0] rx_byte
);

    eng_state_t     state_q;
    eng_state_t     state_d;
    logic [HCW-1:0] hcnt_q;
    logic [BCW-1:0] bit_q;
    logic [FW-1:0]  tx_sh;
    logic [FW-1:0]  rx_sh;
    logic           half_done;
    logic           last_bit;
    logic           miso_i;
    logic           start;

    assign half_done = (hcnt_q == HCW'(HALF - 1));
    assign last_bit  = (bit_q == BCW'(FW - 1));
    assign start     = run_ok && tx_avail;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_SETUP;
            ST_SETUP: if (half_done) state_d = ST_LEAD;
            ST_LEAD:  if (half_done) state_d = ST_TRAIL;
            ST_TRAIL: if (half_done) state_d = last_bit ? ST_HOLD : ST_LEAD;
            ST_HOLD:  if (half_done) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (clr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // half-period timer, bit counter and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (clr) begin
            hcnt_q <= '0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            if (state_q == ST_IDLE || half_done) begin
                hcnt_q <= '0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
            if (tx_take) begin
                tx_sh <= tx_byte;
                bit_q <= '0;
            end
            if (state_q == ST_LEAD && half_done) begin
                rx_sh <= lsb_first ? {miso_i, rx_sh[FW-1:1]} : {rx_sh[FW-2:0], miso_i};
            end
            if (state_q == ST_TRAIL && half_done) begin
                tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_take = 1'b0;
        rx_put  = 1'b0;
        sclk    = cpol;
        unique case (state_q)
            ST_IDLE:  tx_take = start;
            ST_SETUP: sclk    = cpol;
            ST_LEAD:  sclk    = cpol ^ cpha;
            ST_TRAIL: sclk    = ~(cpol ^ cpha);
            ST_HOLD:  rx_put  = half_done;
            default:  sclk    = cpol;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign mosi    = lsb_first ? tx_sh[0] : tx_sh[FW-1];
    assign miso_i  = loop_en ? mosi : miso;
    assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_regbus_master.sv
module spi_regbus_master
    import spi_rb_pkg::*;
#(
    parameter int NUM_SS = 4,
    parameter int DEPTH  = 16,
    parameter int DIV    = 4,
    parameter int IRQ_W  = 9,
    localparam int FW    = 8,
    localparam int OCC_W = $clog2(DEPTH),
    localparam int CNT_W = OCC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_SS-1:0] spi_ss_n
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_SS-1:0] sel_q;
    logic              gie_q;
    logic [IRQ_W-1:0]  isr_q;
    logic [IRQ_W-1:0]  ier_q;

    logic              srst;
    logic              ctrl_wr;
    logic              tx_clr;
    logic              rx_clr;
    logic              tx_push;
    logic              rx_pop_req;
    logic              run_ok;
    logic              ss_manual;
    logic              cpol;

    logic [FW-1:0]     tx_dout;
    logic              tx_full;
    logic              tx_empty;
    logic [CNT_W-1:0]  tx_cnt;
    logic [FW-1:0]     rx_dout;
    logic              rx_full;
    logic              rx_empty;
    logic [CNT_W-1:0]  rx_cnt;

    logic              eng_take;
    logic              eng_busy;
    logic              eng_put;
    logic [FW-1:0]     eng_rx;

    logic [31:0]       rdata_c;

    assign srst       = bus_wr && (bus_addr == OFS_SRST) && (bus_wdata == SRST_KEY);
    assign ctrl_wr    = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_clr     = srst || (ctrl_wr && bus_wdata[CB_TXCLR]);
    assign rx_clr     = srst || (ctrl_wr && bus_wdata[CB_RXCLR]);
    assign tx_push    = bus_wr && (bus_addr == OFS_TXD);
    assign rx_pop_req = bus_rd && (bus_addr == OFS_RXD);
    assign run_ok     = ctrl_q[CB_ENABLE] && ctrl_q[CB_MASTER] && !ctrl_q[CB_HOLD];
    assign ss_manual  = ctrl_q[CB_MANSEL];
    assign cpol       = ctrl_q[CB_CPOL];

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            sel_q  <= '1;
            gie_q  <= 1'b0;
            isr_q  <= '0;
            ier_q  <= '0;
        end else if (srst) begin
            ctrl_q <= CTRL_RESET;
            sel_q  <= '1;
            gie_q  <= 1'b0;
            isr_q  <= '0;
            ier_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0] & ~CTRL_PULSE_MK;
                OFS_SEL:  sel_q  <= bus_wdata[NUM_SS-1:0];
                OFS_GIE:  gie_q  <= bus_wdata[31];
                OFS_ISR:  isr_q  <= bus_wdata[IRQ_W-1:0];
                OFS_IER:  ier_q  <= bus_wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    spi_rb_fifo #(.W(FW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .din   (bus_wdata[FW-1:0]),
        .pop   (eng_take),
        .dout  (tx_dout),
        .full  (tx_full),
        .empty (tx_empty),
        .count (tx_cnt)
    );

    spi_rb_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (eng_put),
        .din   (eng_rx),
        .pop   (rx_pop_req),
        .dout  (rx_dout),
        .full  (rx_full),
        .empty (rx_empty),
        .count (rx_cnt)
    );

    spi_rb_engine #(.DIV(DIV), .FW(FW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .run_ok    (run_ok),
        .tx_avail  (!tx_empty),
        .tx_byte   (tx_dout),
        .tx_take   (eng_take),
        .cpol      (cpol),
        .cpha      (ctrl_q[CB_CPHA]),
        .lsb_first (ctrl_q[CB_LSBF]),
        .loop_en   (ctrl_q[CB_LOOP]),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .busy      (eng_busy),
        .rx_put    (eng_put),
        .rx_byte   (eng_rx)
    );

    assign spi_ss_n = (ss_manual || eng_busy) ? sel_q : '1;

    // read mux
    always_comb begin
        rdata_c = '0;
        case (bus_addr)
            OFS_GIE:   rdata_c[31]          = gie_q;
            OFS_ISR:   rdata_c[IRQ_W-1:0]   = isr_q;
            OFS_IER:   rdata_c[IRQ_W-1:0]   = ier_q;
            OFS_CTRL:  rdata_c[CTRL_W-1:0]  = ctrl_q;
            OFS_STAT:  rdata_c[3:0]         = {tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:   rdata_c[FW-1:0]      = rx_empty ? '0 : rx_dout;
            OFS_SEL:   rdata_c[NUM_SS-1:0]  = sel_q;
            OFS_TXOCC: rdata_c[OCC_W-1:0]   = tx_cnt[OCC_W-1:0] - 1'b1;
            OFS_RXOCC: rdata_c[OCC_W-1:0]   = rx_cnt[OCC_W-1:0] - 1'b1;
            default:   rdata_c              = '0;
        endcase
    end

    assign bus_rdata = rdata_c;

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
    parameter int NUM_SS = 4,
    parameter int CNT_W  = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              run_ok,
    input logic              manual,
    input logic              cpol,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              tx_full,
    input logic              tx_push,
    input logic              tx_pop,
    input logic              tx_clr,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              rd_rx,
    input logic [31:0]       rdata,
    input logic              srst
);

    AST_SS_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !busy) |-> (ss_n == '1)); // R8

    AST_HELD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !busy) |=> !busy); // R4

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol)); // R5

    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH)); // R9

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop && !tx_clr) |=> tx_full); // R9

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |-> (rdata == 32'h0)); // R10

    AST_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (tx_empty && rx_empty && !busy && ss_n == '1)); // R3

endmodule

bind spi_regbus_master spi_rb_checker #(
    .NUM_SS (NUM_SS),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .run_ok   (run_ok),
    .manual   (ss_manual),
    .cpol     (cpol),
    .sclk     (spi_sclk),
    .ss_n     (spi_ss_n),
    .tx_cnt   (tx_cnt),
    .tx_full  (tx_full),
    .tx_push  (tx_push),
    .tx_pop   (eng_take),
    .tx_clr   (tx_clr),
    .tx_empty (tx_empty),
    .rx_empty (rx_empty),
    .rd_rx    (rx_pop_req),
    .rdata    (bus_rdata),
    .srst     (srst)
);

// File: tb/spi_regbus_master_tb_top.sv
module spi_regbus_master_tb_top;

    localparam logic [7:0] A_GIE = 8'h1C, A_ISR = 8'h20, A_IER = 8'h28, A_SRST = 8'h40;
    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68, A_RXD = 8'h6C;
    localparam logic [7:0] A_SEL = 8'h70, A_TXOCC = 8'h74, A_RXOCC = 8'h78;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b1;
    logic [3:0]  spi_ss_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] exp_rx[$];
    logic [7:0] exp_mosi[$];
    logic [7:0] slv_resp[$];
    logic [7:0] got_mosi[$];

    bit m_cpol = 0, m_cpha = 0, m_lsb = 0;

    always #5 clk = ~clk;

    spi_regbus_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_ss_n  (spi_ss_n)
    );

    // external device model on select line 0
    logic       ss0_prev = 1'b1;
    logic       sclk_prev = 1'b0;
    logic [7:0] s_resp = 8'hFF;
    logic [7:0] s_cap = 8'h00;
    int         s_cnt = 0;

    always @(spi_ss_n[0] or spi_sclk) begin
        if (spi_ss_n[0] !== ss0_prev) begin
            if (spi_ss_n[0] === 1'b0) begin
                s_resp = (slv_resp.size() > 0) ? slv_resp.pop_front() : 8'hFF;
                s_cnt  = 0;
                s_cap  = 8'h00;
                spi_miso = m_lsb ? s_resp[0] : s_resp[7];
            end else if (spi_ss_n[0] === 1'b1 && s_cnt == 8) begin
                got_mosi.push_back(s_cap);
                s_cnt = 0;
            end
        end else if (spi_sclk !== sclk_prev && spi_ss_n[0] === 1'b0) begin
            if (spi_sclk == (m_cpol == m_cpha)) begin
                if (s_cnt < 8) begin
                    s_cap[m_lsb ? s_cnt : 7 - s_cnt] = spi_mosi;
                    s_cnt++;
                end
            end else if (s_cnt < 8) begin
                spi_miso = s_resp[m_lsb ? s_cnt : 7 - s_cnt];
            end
        end
        ss0_prev  = spi_ss_n[0];
        sclk_prev = spi_sclk;
    end

    // clock monitors
    int         sclk_edges = 0;
    time        last_rise = 0;
    time        rise_per = 0;
    logic [3:0] ss_at_edge = 4'hF;

    always @(spi_sclk) begin
        sclk_edges++;
        ss_at_edge = spi_ss_n;
    end

    always @(posedge spi_sclk) begin
        if (last_rise != 0 && spi_ss_n !== 4'hF && ($time - last_rise) < 60)
            rise_per = $time - last_rise;
        last_rise = $time;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic wait_stat(input int bitn, input logic val, input string req);
        logic [31:0] d;
        int tries = 0;
        bus_read(A_STAT, d);
        while (d[bitn] !== val && tries < 3000) begin
            bus_read(A_STAT, d);
            tries++;
        end
        if (d[bitn] !== val) chk(req, {31'b0, d[bitn]}, {31'b0, val});
    endtask

    // driver: queue one frame and its expected results
    task automatic send(input logic [7:0] b, input logic [7:0] resp, input bit slv, input bit keep);
        if (slv) begin
            slv_resp.push_back(resp);
            exp_mosi.push_back(b);
        end
        if (keep) exp_rx.push_back(slv ? resp : b);
        bus_write(A_TXD, {24'h0, b});
    endtask

    // monitor: pop received frames and compare against the scoreboard
    task automatic drain(input int n, input bit slv, input string req);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            wait_stat(0, 1'b0, req);
            bus_read(A_RXD, d);
            chk(req, d, {24'h0, exp_rx.pop_front()});
            if (slv) begin
                if (got_mosi.size() == 0) chk(req, 32'hDEAD, {24'h0, exp_mosi.pop_front()});
                else chk(req, {24'h0, got_mosi.pop_front()}, {24'h0, exp_mosi.pop_front()});
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e0;
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12 reset state
        rd_chk("R1", A_CTRL, 32'h180);
        rd_chk("R12", A_STAT, 32'h05);
        rd_chk("R1", A_SEL, 32'hF);
        chk("R1", {31'b0, spi_sclk}, 32'h0);
        chk("R1", {28'b0, spi_ss_n}, 32'hF);

        // R2 interrupt storage
        bus_write(A_GIE, 32'hFFFF_FFFF);
        rd_chk("R2", A_GIE, 32'h8000_0000);
        bus_write(A_ISR, 32'h0000_0155);
        rd_chk("R2", A_ISR, 32'h155);
        bus_write(A_IER, 32'hFFFF_FFFF);
        rd_chk("R2", A_IER, 32'h1FF);

        // R4 frames held in the queue
        bus_write(A_CTRL, 32'h186);
        e0 = sclk_edges;
        send(8'hA5, 8'h00, 0, 0);
        repeat (60) @(negedge clk);
        rd_chk("R4", A_STAT, 32'h01);
        rd_chk("R9", A_TXOCC, 32'h0);
        bus_write(A_CTRL, 32'h084);
        repeat (60) @(negedge clk);
        bus_write(A_CTRL, 32'h082);
        repeat (60) @(negedge clk);
        chk("R4", sclk_edges - e0, 0);
        rd_chk("R4", A_STAT, 32'h01);

        // R11 transmit queue clear
        bus_write(A_CTRL, 32'h1A6);
        rd_chk("R11", A_STAT, 32'h05);
        rd_chk("R11", A_CTRL, 32'h186);

        // R5 / R6 / R8 all modes, automatic select, device 0
        bus_write(A_SEL, 32'hE);
        for (int m = 0; m < 8; m++) begin
            m_cpol = m[0]; m_cpha = m[1]; m_lsb = m[2];
            bus_write(A_CTRL, {22'h0, m_lsb, 4'b0, m_cpha, m_cpol, 3'b110});
            repeat (4) @(negedge clk);
            chk("R5", {31'b0, spi_sclk}, {31'b0, m_cpol});
            chk("R8", {28'b0, spi_ss_n}, 32'hF);
            rise_per = 0;
            send(8'h96 ^ 8'(m * 17), 8'h3B + 8'(m * 29), 1, 1);
            send(8'h01 << m, 8'hC4 ^ 8'(m), 1, 1);
            drain(2, 1, m[2] ? "R6" : "R5");
            chk("R5", 32'(rise_per), 32'd40);
            chk("R8", {28'b0, ss_at_edge}, 32'hE);
            chk("R8", {28'b0, spi_ss_n}, 32'hF);
        end
        m_cpol = 0; m_cpha = 0; m_lsb = 0;

        // R7 / R8 loopback with manual select of device 2
        bus_write(A_SEL, 32'hB);
        bus_write(A_CTRL, 32'h087);
        repeat (2) @(negedge clk);
        chk("R8", {28'b0, spi_ss_n}, 32'hB);
        send(8'h3C, 8'h00, 0, 1);
        send(8'hC3, 8'h00, 0, 1);
        drain(2, 0, "R7");
        chk("R8", {28'b0, spi_ss_n}, 32'hB);

        // R9 full queue drops the seventeenth write
        bus_write(A_CTRL, 32'h187);
        for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), 8'h00, 0, i < 16);
        rd_chk("R9", A_STAT, 32'h09);
        rd_chk("R9", A_TXOCC, 32'hF);
        bus_write(A_CTRL, 32'h087);
        wait_stat(1, 1'b1, "R9");
        wait_stat(2, 1'b1, "R9");
        rd_chk("R12", A_STAT, 32'h06);
        rd_chk("R9", A_RXOCC, 32'hF);
        drain(16, 0, "R9");
        rd_chk("R9", A_STAT, 32'h05);

        // R10 empty read
        rd_chk("R10", A_RXD, 32'h0);
        rd_chk("R10", A_STAT, 32'h05);
        send(8'h5A, 8'h00, 0, 1);
        drain(1, 0, "R10");

        // R11 receive queue clear
        send(8'h11, 8'h00, 0, 0);
        send(8'h22, 8'h00, 0, 0);
        wait_stat(2, 1'b1, "R11");
        repeat (60) @(negedge clk);
        rd_chk("R11", A_RXOCC, 32'h1);
        bus_write(A_CTRL, 32'h0C7);
        rd_chk("R11", A_STAT, 32'h05);
        rd_chk("R11", A_CTRL, 32'h087);

        // R3 keyed reset
        bus_write(A_SRST, 32'h0000_0005);
        rd_chk("R3", A_CTRL, 32'h087);
        rd_chk("R3", A_SEL, 32'hB);
        bus_write(A_SRST, 32'h0000_000A);
        rd_chk("R3", A_CTRL, 32'h180);
        rd_chk("R3", A_SEL, 32'hF);
        rd_chk("R3", A_ISR, 32'h0);
        bus_read(A_GIE, d);
        chk("R3", d, 32'h0);

        finish_run();
    end

endmodule